// File: doc/BRIEF.md
# Used-Bit Page Reclaim Engine

This block decides which resident page frames can be given back to the free pool. Each frame in a small table has three bits: resident, used and dirty. Memory references to a resident frame set its used bit, and write references also set its dirty bit. Allocating a frame makes it resident again, with its used bit set and its dirty bit clear.

Each accepted reclaim step moves two pointers forward by one frame. The clearing pointer wipes the used bit of the frame it visits. The scanning pointer follows a fixed number of frames behind it and looks at frames the clearing pointer has already visited. A frame that has not been touched since it was cleared is released on the free stream. If the frame is dirty, a write-back request is raised instead, and it is held until it is acknowledged. The acknowledgement cleans the frame, and it can be released on a later pass.

The storage of the free list and the disk transfer itself are outside the block.

Top module: `page_reclaim_engine`

## Requirements
- R1: A reference to a resident frame sets its used bit. A frame referenced after its used bit was cleared and before the scanning pointer reaches it is not released on that pass.
- R2: A write reference to a resident frame sets its dirty bit. A dirty frame is never placed on the free stream.
- R3: After reset the clearing pointer is at frame GAP and the scanning pointer is at frame 0. Each accepted step advances both pointers by one frame, wrapping modulo NUM_FRAMES, so a frame is scanned exactly GAP accepted steps after it was cleared.
- R4: An accepted step clears the used bit of the frame under the clearing pointer.
- R5: If an accepted step finds the scanned frame resident, unused and clean, then in the next cycle free_valid_o is high for exactly one cycle with free_frame_o equal to that frame, and the frame becomes non-resident.
- R6: If an accepted step finds the scanned frame resident, unused and dirty, then from the next cycle wb_valid_o stays high with a stable wb_frame_o until the cycle in which wb_ack_i is high. That acknowledgement clears the dirty bit and leaves the frame resident, so it is released on a later pass if it is still unused.
- R7: A step request that arrives while a write-back request is pending is ignored, and the pointers do not move. free_valid_o and wb_valid_o are never high together.
- R8: When a reference and the clearing pointer hit the same frame in the same cycle, the reference wins and the used bit ends up set. A reference or an allocation of the scanned frame in the step's cycle prevents that frame from being reclaimed.
- R9: A non-resident frame is passed over by both pointers, and references to it have no effect. Allocation makes a frame resident with used set and dirty clear, and it takes priority over a release of that frame in the same cycle.
- R10: Reset leaves every frame non-resident and both free_valid_o and wb_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | 1 | A reference to a frame is made this cycle |
| ref_frame_i | input | FRAME_W | Frame referenced |
| ref_write_i | input | 1 | The reference is a write |
| alloc_valid_i | input | 1 | A frame is (re)allocated this cycle |
| alloc_frame_i | input | FRAME_W | Frame allocated |
| step_i | input | 1 | Request one reclaim step |
| wb_ack_i | input | 1 | The pending write-back request is accepted |
| free_valid_o | output | 1 | One-cycle pulse: a frame is released |
| free_frame_o | output | FRAME_W | Frame released |
| wb_valid_o | output | 1 | A write-back request is pending |
| wb_frame_o | output | FRAME_W | Frame to be written back |

## Verification
The hardest cases to reach are the cycles where the two pointers meet other traffic. One is a reference landing on a frame in the same cycle the clearing pointer wipes it. Another is a frame that goes through write-back and is released a full revolution later. Directed sequences handle these. They first walk the pointers to a known position, counting accepted steps from reset. They then place the reference, or the write and its delayed acknowledgement, on exactly the cycle needed, and send extra step requests while the request is pending to show that the pointers stall. A long random phase follows, in which references, writes, allocations, steps and acknowledgements overlap. Throughout it, a reference model predicts every free and write-back item that should appear.

// File: rtl/reclaim_pkg.sv
package reclaim_pkg;
  typedef enum logic [1:0] {
    VERDICT_SKIP = 2'd0,   // not resident or no step
    VERDICT_KEEP = 2'd1,   // still in use
    VERDICT_FREE = 2'd2,
    VERDICT_WB   = 2'd3
  } verdict_e;
endpackage

// File: rtl/reclaim_frame_table.sv
module reclaim_frame_table #(
  parameter int NUM_FRAMES = 16,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ref_valid_i,
  input  logic [FRAME_W-1:0]    ref_frame_i,
  input  logic                  ref_write_i,
  input  logic                  alloc_valid_i,
  input  logic [FRAME_W-1:0]    alloc_frame_i,
  input  logic                  clr_valid_i,
  input  logic [FRAME_W-1:0]    clr_frame_i,
  input  logic                  drop_valid_i,
  input  logic [FRAME_W-1:0]    drop_frame_i,
  input  logic                  clean_valid_i,
  input  logic [FRAME_W-1:0]    clean_frame_i,
  output logic [NUM_FRAMES-1:0] resident_o,
  output logic [NUM_FRAMES-1:0] used_o,
  output logic [NUM_FRAMES-1:0] dirty_o
);

  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    localparam logic [FRAME_W-1:0] IDX = FRAME_W'(i);
    logic ref_hit, alloc_hit, clr_hit, drop_hit, clean_hit;

    assign ref_hit   = ref_valid_i   && (ref_frame_i   == IDX) && resident_o[i];
    assign alloc_hit = alloc_valid_i && (alloc_frame_i == IDX);
    assign clr_hit   = clr_valid_i   && (clr_frame_i   == IDX);
    assign drop_hit  = drop_valid_i  && (drop_frame_i  == IDX);
    assign clean_hit = clean_valid_i && (clean_frame_i == IDX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        resident_o[i] <= 1'b0;
        used_o[i]     <= 1'b0;
        dirty_o[i]    <= 1'b0;
      end else begin
        // priority: alloc > reference > clear
        if (alloc_hit)      used_o[i] <= 1'b1;
        else if (ref_hit)   used_o[i] <= 1'b1;
        else if (clr_hit)   used_o[i] <= 1'b0;

        if (alloc_hit)                    dirty_o[i] <= 1'b0;
        else if (ref_hit && ref_write_i)  dirty_o[i] <= 1'b1;
        else if (clean_hit)               dirty_o[i] <= 1'b0;

        if (alloc_hit)      resident_o[i] <= 1'b1;
        else if (drop_hit)  resident_o[i] <= 1'b0;
      end
    end
  end

  AST_REF_SETS_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && resident_o[ref_frame_i]) |=> used_o[$past(ref_frame_i)]); // R1

  AST_WRITE_SETS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_valid_i && ref_write_i && resident_o[ref_frame_i] &&
     !(alloc_valid_i && alloc_frame_i == ref_frame_i))
    |=> dirty_o[$past(ref_frame_i)]); // R2

  AST_ALLOC_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_valid_i |=> (resident_o[$past(alloc_frame_i)] && used_o[$past(alloc_frame_i)]
                       && !dirty_o[$past(alloc_frame_i)])); // R9

endmodule

// File: rtl/reclaim_pointers.sv
module reclaim_pointers #(
  parameter int NUM_FRAMES = 16,
  parameter int GAP        = 4,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_go_i,
  output logic [FRAME_W-1:0] clear_ptr_o,
  output logic [FRAME_W-1:0] scan_ptr_o
);

  localparam logic [FRAME_W-1:0] LAST    = FRAME_W'(NUM_FRAMES - 1);
  localparam logic [FRAME_W-1:0] GAP_IDX = FRAME_W'(GAP % NUM_FRAMES);

  function automatic logic [FRAME_W-1:0] wrap_inc(input logic [FRAME_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clear_ptr_o <= GAP_IDX;
      scan_ptr_o  <= '0;
    end else if (step_go_i) begin
      clear_ptr_o <= wrap_inc(clear_ptr_o);
      scan_ptr_o  <= wrap_inc(scan_ptr_o);
    end
  end

  AST_PTR_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(clear_ptr_o) == (int'(scan_ptr_o) + GAP) % NUM_FRAMES); // R3

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_go_i |=> int'(scan_ptr_o) == (int'($past(scan_ptr_o)) + 1) % NUM_FRAMES); // R3

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_go_i |=> $stable(scan_ptr_o) && $stable(clear_ptr_o)); // R7

endmodule

// File: rtl/reclaim_issue.sv
module reclaim_issue
  import reclaim_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               wb_ack_i,
  input  logic [FRAME_W-1:0] scan_ptr_i,
  input  logic               scan_resident_i,
  input  logic               scan_used_i,
  input  logic               scan_dirty_i,
  input  logic               scan_touched_i,
  output logic               step_go_o,
  output logic               drop_valid_o,
  output logic               clean_valid_o,
  output logic               free_valid_o,
  output logic [FRAME_W-1:0] free_frame_o,
  output logic               wb_valid_o,
  output logic [FRAME_W-1:0] wb_frame_o
);

  verdict_e verdict;

  assign step_go_o = step_i && !wb_valid_o;

  always_comb begin
    verdict = VERDICT_SKIP;
    if (step_go_o && scan_resident_i) begin
      if (scan_used_i || scan_touched_i) verdict = VERDICT_KEEP;
      else if (scan_dirty_i)             verdict = VERDICT_WB;
      else                               verdict = VERDICT_FREE;
    end
  end

  assign drop_valid_o  = (verdict == VERDICT_FREE);
  assign clean_valid_o = wb_valid_o && wb_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_valid_o <= 1'b0;
      free_frame_o <= '0;
      wb_valid_o   <= 1'b0;
      wb_frame_o   <= '0;
    end else begin
      free_valid_o <= drop_valid_o;
      if (drop_valid_o) free_frame_o <= scan_ptr_i;
      if (clean_valid_o) begin
        wb_valid_o <= 1'b0;
      end else if (verdict == VERDICT_WB) begin
        wb_valid_o <= 1'b1;
        wb_frame_o <= scan_ptr_i;
      end
    end
  end

  AST_WB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ack_i) |=> (wb_valid_o && $stable(wb_frame_o))); // R6

  AST_WB_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && wb_ack_i) |=> !wb_valid_o); // R6

  AST_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> !step_go_o); // R7

  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(free_valid_o && wb_valid_o)); // R7

  AST_FREE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_valid_o |=> !free_valid_o || $past(step_i)); // R5

endmodule

// File: rtl/page_reclaim_engine.sv
module page_reclaim_engine #(
  parameter int NUM_FRAMES = 16,
  parameter int GAP        = 4,
  parameter int FRAME_W    = $clog2(NUM_FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_valid_i,
  input  logic [FRAME_W-1:0] ref_frame_i,
  input  logic               ref_write_i,
  input  logic               alloc_valid_i,
  input  logic [FRAME_W-1:0] alloc_frame_i,
  input  logic               step_i,
  input  logic               wb_ack_i,
  output logic               free_valid_o,
  output logic [FRAME_W-1:0] free_frame_o,
  output logic               wb_valid_o,
  output logic [FRAME_W-1:0] wb_frame_o
);

  logic [NUM_FRAMES-1:0] resident, used, dirty;
  logic [FRAME_W-1:0]    clear_ptr, scan_ptr;
  logic                  step_go, drop_valid, clean_valid, scan_touched;

  reclaim_pointers #(
    .NUM_FRAMES(NUM_FRAMES), .GAP(GAP), .FRAME_W(FRAME_W)
  ) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_go_i   (step_go),
    .clear_ptr_o (clear_ptr),
    .scan_ptr_o  (scan_ptr)
  );

  // a same-cycle reference or allocation keeps the scanned frame alive
  assign scan_touched = (ref_valid_i && ref_frame_i == scan_ptr && resident[scan_ptr]) ||
                        (alloc_valid_i && alloc_frame_i == scan_ptr);

  reclaim_issue #(.FRAME_W(FRAME_W)) u_issue (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .step_i          (step_i),
    .wb_ack_i        (wb_ack_i),
    .scan_ptr_i      (scan_ptr),
    .scan_resident_i (resident[scan_ptr]),
    .scan_used_i     (used[scan_ptr]),
    .scan_dirty_i    (dirty[scan_ptr]),
    .scan_touched_i  (scan_touched),
    .step_go_o       (step_go),
    .drop_valid_o    (drop_valid),
    .clean_valid_o   (clean_valid),
    .free_valid_o    (free_valid_o),
    .free_frame_o    (free_frame_o),
    .wb_valid_o      (wb_valid_o),
    .wb_frame_o      (wb_frame_o)
  );

  reclaim_frame_table #(
    .NUM_FRAMES(NUM_FRAMES), .FRAME_W(FRAME_W)
  ) u_table (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ref_valid_i   (ref_valid_i),
    .ref_frame_i   (ref_frame_i),
    .ref_write_i   (ref_write_i),
    .alloc_valid_i (alloc_valid_i),
    .alloc_frame_i (alloc_frame_i),
    .clr_valid_i   (step_go),
    .clr_frame_i   (clear_ptr),
    .drop_valid_i  (drop_valid),
    .drop_frame_i  (scan_ptr),
    .clean_valid_i (clean_valid),
    .clean_frame_i (wb_frame_o),
    .resident_o    (resident),
    .used_o        (used),
    .dirty_o       (dirty)
  );

  AST_FREED_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_valid_o |-> !resident[free_frame_o]); // R5

  AST_WB_RESIDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !$past(wb_valid_o)) |-> resident[wb_frame_o]); // R6

endmodule

// File: tb/page_reclaim_engine_tb.sv
module page_reclaim_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int GAP = 4;
  localparam int FW  = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_v = 0, ref_w = 0, alloc_v = 0, step = 0, ack = 0;
  logic [FW-1:0] ref_f = '0, alloc_f = '0;
  logic free_v, wb_v;
  logic [FW-1:0] free_f, wb_f;

  int checks = 0, errors = 0;
  int free_q[$], wb_q[$];
  int free_seen[N];
  bit m_res[N], m_used[N], m_dirty[N];
  int m_clr, m_scn, m_pend_f;
  bit m_pend, wb_prev, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_reclaim_engine #(.NUM_FRAMES(N), .GAP(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ref_valid_i(ref_v), .ref_frame_i(ref_f), .ref_write_i(ref_w),
    .alloc_valid_i(alloc_v), .alloc_frame_i(alloc_f),
    .step_i(step), .wb_ack_i(ack),
    .free_valid_o(free_v), .free_frame_o(free_f),
    .wb_valid_o(wb_v), .wb_frame_o(wb_f)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected items as the design emits them
  always @(negedge clk) begin
    if (rst_n) begin
      if (free_v) begin
        if (free_q.size() == 0) chk("R5 unexpected free", int'(free_f), -1);
        else chk("R3/R5 free frame", int'(free_f), free_q.pop_front());
        free_seen[free_f]++;
      end
      if (wb_v && !wb_prev) begin
        if (wb_q.size() == 0) chk("R6 unexpected write-back", int'(wb_f), -1);
        else chk("R3/R6 write-back frame", int'(wb_f), wb_q.pop_front());
      end
      wb_prev = wb_v;
    end
  end

  // driver: one cycle of stimulus plus the reference model update
  task automatic cyc(input bit rv, input int rf, input bit rw, input bit av,
                     input int af, input bit st, input bit ak);
    bit go, ref_ok, keep;
    int s;
    @(negedge clk);
    ref_v = rv; ref_f = FW'(rf); ref_w = rw;
    alloc_v = av; alloc_f = FW'(af); step = st; ack = ak;
    go = st && !m_pend;
    ref_ok = rv && m_res[rf];
    s = m_scn;
    keep = (ref_ok && rf == s) || (av && af == s);
    if (ak && m_pend) begin m_dirty[m_pend_f] = 0; m_pend = 0; end
    if (go) begin
      if (m_res[s] && !m_used[s] && !keep) begin
        if (m_dirty[s]) begin wb_q.push_back(s); m_pend = 1; m_pend_f = s; end
        else begin free_q.push_back(s); m_res[s] = 0; end
      end
      m_used[m_clr] = 0;
      m_clr = (m_clr + 1) % N;
      m_scn = (m_scn + 1) % N;
    end
    if (ref_ok) begin m_used[rf] = 1; if (rw) m_dirty[rf] = 1; end
    if (av) begin m_res[af] = 1; m_used[af] = 1; m_dirty[af] = 0; end
    @(posedge clk); #1;
    chk("R6/R7 write-back pending", int'(wb_v), int'(m_pend));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    m_clr = GAP; m_scn = 0; m_pend = 0; m_pend_f = 0;
    for (int i = 0; i < N; i++) free_seen[i] = 0;
    repeat (3) @(negedge clk);
    chk("R10 free_valid in reset", int'(free_v), 0);
    chk("R10 wb_valid in reset", int'(wb_v), 0);
    rst_n = 1'b1;
    // R10/R9: no frame resident, a full sweep frees nothing
    steps(N);
    idle(1);
    chk("R10 nothing freed after reset", free_q.size() + int'(free_v), 0);
    // pointers now back at clear=GAP, scan=0
    // R8: reference on frame 4 in the same cycle its used bit is cleared
    cyc(0, 0, 0, 1, 4, 0, 0);
    cyc(1, 4, 0, 0, 0, 1, 0);
    steps(GAP);            // scan reaches frame 4 on the last of these
    idle(1);
    chk("R8 referenced frame kept", free_seen[4], 0);
    steps(N);              // R4: cleared again, then scanned with used clear
    idle(1);
    chk("R4/R5 frame freed after clear", free_seen[4], 1);
    // pointers: clear=(4+1+GAP+N)%N=9, scan=5
    cyc(0, 0, 0, 1, 9, 0, 0);
    cyc(1, 9, 1, 0, 0, 0, 0);     // R2 write makes it dirty
    steps(GAP + 1);               // clear 9, then scan 9 -> write-back
    steps(3);                     // R7 ignored while pending
    chk("R6 wb_valid held", int'(wb_v), 1);
    chk("R6 wb_frame", int'(wb_f), 9);
    chk("R2 dirty frame not freed", free_seen[9], 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    steps(N);
    idle(1);
    chk("R6 cleaned frame freed later", free_seen[9], 1);
    // R9: writes to a non-resident frame do nothing
    cyc(1, 9, 1, 0, 0, 0, 0);
    steps(2 * N);
    idle(1);
    chk("R9 non-resident frame ignored", free_seen[9] + int'(wb_v), 1);
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) == 0, $urandom % N, $urandom % 2,
          ($urandom % 8) == 0, $urandom % N, ($urandom % 2) == 0,
          m_pend && (($urandom % 3) == 0));
    end
    while (m_pend) cyc(0, 0, 0, 0, 0, 0, 1);
    idle(2);
    chk("R5 free items all seen", free_q.size(), 0);
    chk("R6 write-back items all seen", wb_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule